// File: doc/BRIEF.md
# SPI Slave with Address Filtering

This block is a serial SPI slave engine that lives entirely in the system clock domain. It brings the serial clock, the MOSI data line and the active-low select through synchronizer flops and detects serial clock edges by oversampling, so the serial clock must be several times slower than the system clock. It uses one fixed clock mode: idle-low clock, MSB first, input sampled on the rising edge, output changed on the falling edge. A configuration input chooses 8-bit or 9-bit characters.

The block has two optional features. With address filtering, the first character of each transaction is compared with a programmed address. On a match the transaction is accepted: the receive strobe fires, a wake request pulses and MISO is driven for the rest of the transaction. On a mismatch the whole transaction is dropped. With transmit preloading, one written character moves into the shift register while select is inactive, so the first character sent is real data. Without preloading, the first character sent is whatever the shift register already holds. The register side has a transmit write port, a received-character port with a one-cycle receive-complete strobe, and a MISO output enable for a shared tri-state line.

Top module: `spi_addr_slave`

## Requirements
- R1: Right after reset, misoOe, rxDone and wakeReq are 0, rxData is 0, and the shift register is all zeros. The first character shifted out after reset is therefore 0.
- R2: Bits move MSB first. MISO holds each bit from the preceding falling serial clock edge until the rising edge that samples MOSI. After the falling edge that follows the last rising edge of a character, rxData holds the received character and rxDone is high for exactly one cycle.
- R3: When nineBit is 1, characters are 9 bits and MISO comes from shift bit 8. When nineBit is 0, characters are 8 bits, MISO comes from bit 7, and rxData[8] reads 0.
- R4: With preloading off, the first character of a transaction is the current shift register content: zero after reset, otherwise the last character received. A pending transmit character is loaded at the first character boundary.
- R5: With preloading on and select inactive (after synchronization), exactly one pending character moves into the shift register. A second character written before select falls waits and is sent as the second character.
- R6: If no transmit character is pending at an accepted character boundary, the shift register keeps the character just received, and that character is shifted out next.
- R7: With addrEn set, the low 8 bits of the first character are compared with addrReg. On a match, rxDone and wakeReq pulse together, MISO is driven for the later characters, and the pending transmit character is sent as the second character.
- R8: With addrEn set and no match, the transaction is ignored. rxDone never pulses, wakeReq stays 0, rxData keeps its value and misoOe stays 0 until select rises.
- R9: misoOe is 0 while select is inactive and during the address character. It is 1 throughout an accepted transaction.
- R10: wakeReq pulses only on an address match. It never pulses when addrEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sckIn | input | 1 | Serial clock pin, idle low |
| mosiIn | input | 1 | Serial data in |
| ssNIn | input | 1 | Active-low select pin |
| misoOut | output | 1 | Serial data out |
| misoOe | output | 1 | Driver enable for the shared MISO line |
| nineBit | input | 1 | 1: 9-bit characters, 0: 8-bit |
| addrEn | input | 1 | Enable address filtering |
| preloadEn | input | 1 | Enable transmit preloading |
| addrReg | input | 8 | Address compared with the first character |
| txWrEn | input | 1 | Write strobe for the transmit data register |
| txWrData | input | 9 | Transmit character |
| rxData | output | 9 | Last accepted received character |
| rxDone | output | 1 | One-cycle receive-complete strobe |
| wakeReq | output | 1 | One-cycle wake request on address match |

## Verification
Every pin passes through two synchronizer flops and one edge-detect register, so each reaction comes about three system cycles after the pin change. MISO updates about three cycles after a falling serial clock edge. rxDone, wakeReq and rxData follow the last falling edge of a character by three cycles. misoOe follows select or the address decision by the same amount. The bench holds every serial clock phase and every select change for at least six cycles, and samples only at the end of those windows. A preload needs four idle cycles after the write, and the bench waits that long before lowering select. Strobes are counted on the falling system clock edge, and the counts are compared after each transaction.

// File: rtl/spi_addr_pkg.sv
package spi_addr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_ACCEPT, PH_REJECT} phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleBit;  // rising serial edge in a live transaction
    logic shiftBit;   // falling serial edge in a live transaction
    logic loadOk;     // accepted character boundary
    logic selIdle;    // synchronized select inactive
    logic txStart;    // synchronized select just fell
  } dpStrobe_t;
endpackage

// File: rtl/spi_addr_sync.sv
module spi_addr_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_addr_ctrl.sv
module spi_addr_ctrl
  import spi_addr_pkg::*;
#(
  parameter int CHAR_W = 9,
  localparam int ADDR_W = CHAR_W - 1,
  localparam int CNT_W = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckS,
  input  logic              ssNS,
  input  logic              nineBit,
  input  logic              addrEn,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic [ADDR_W-1:0] addrWord,
  output dpStrobe_t         strb,
  output logic              rxDone,
  output logic              wakeReq,
  output logic              misoOe,
  output logic              selActive
);
  phase_e phase;
  logic sckPrev, ssPrev;
  logic [CNT_W-1:0] bitCnt, charLen;
  logic sckRise, sckFall, txStart, live, charEnd, match, accept;

  assign sckRise   = sckS & ~sckPrev;
  assign sckFall   = ~sckS & sckPrev;
  assign txStart   = ssPrev & ~ssNS;
  assign selActive = ~ssNS;
  assign live      = selActive && (phase == PH_ADDR || phase == PH_ACCEPT);
  assign charLen   = nineBit ? CNT_W'(CHAR_W) : CNT_W'(CHAR_W - 1);
  assign charEnd   = live && sckFall && (bitCnt == charLen);
  assign match     = (addrWord == addrReg);
  assign accept    = (phase == PH_ACCEPT) || (phase == PH_ADDR && match);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      ssPrev  <= 1'b1;
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      rxDone  <= 1'b0;
      wakeReq <= 1'b0;
    end else begin
      sckPrev <= sckS;
      ssPrev  <= ssNS;
      rxDone  <= charEnd && accept;
      wakeReq <= charEnd && phase == PH_ADDR && match;
      if (ssNS) phase <= PH_IDLE;
      else if (txStart) phase <= addrEn ? PH_ADDR : PH_ACCEPT;
      else if (charEnd && phase == PH_ADDR) phase <= match ? PH_ACCEPT : PH_REJECT;
      if (!live || txStart) bitCnt <= '0;
      else if (sckRise) bitCnt <= bitCnt + 1'b1;
      else if (charEnd) bitCnt <= '0;
    end
  end

  always_comb begin
    strb.sampleBit = live && sckRise;
    strb.shiftBit  = live && sckFall;
    strb.loadOk    = charEnd && accept;
    strb.selIdle   = ssNS;
    strb.txStart   = txStart;
  end

  assign misoOe = selActive && phase == PH_ACCEPT;
endmodule

// File: rtl/spi_addr_dp.sv
module spi_addr_dp
  import spi_addr_pkg::*;
#(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              mosiS,
  input  logic              nineBit,
  input  logic              preloadEn,
  input  logic              txWrEn,
  input  logic [CHAR_W-1:0] txWrData,
  output logic              misoOut,
  output logic [CHAR_W-1:0] rxData,
  output logic [CHAR_W-1:0] charWord
);
  logic [CHAR_W-1:0] shReg, dataReg, shifted;
  logic dataValid, sampled, preloaded, doPreload, doLoad;

  assign shifted   = {shReg[CHAR_W-2:0], sampled};
  assign charWord  = nineBit ? shifted : {1'b0, shifted[CHAR_W-2:0]};
  assign doPreload = strb.selIdle && preloadEn && dataValid && !preloaded;
  assign doLoad    = strb.loadOk && dataValid;
  assign misoOut   = nineBit ? shReg[CHAR_W-1] : shReg[CHAR_W-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      dataReg   <= '0;
      dataValid <= 1'b0;
      sampled   <= 1'b0;
      preloaded <= 1'b0;
      rxData    <= '0;
    end else begin
      if (doPreload || doLoad) shReg <= dataReg;
      else if (strb.shiftBit) shReg <= shifted;
      if (txWrEn) dataReg <= txWrData;
      dataValid <= txWrEn || (dataValid && !(doPreload || doLoad));
      if (strb.txStart) preloaded <= 1'b0;
      else if (doPreload) preloaded <= 1'b1;
      if (strb.sampleBit) sampled <= mosiS;
      if (strb.loadOk) rxData <= charWord;
    end
  end
endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
  import spi_addr_pkg::*;
#(
  parameter int CHAR_W = 9,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = CHAR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssNIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              nineBit,
  input  logic              addrEn,
  input  logic              preloadEn,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic              txWrEn,
  input  logic [CHAR_W-1:0] txWrData,
  output logic [CHAR_W-1:0] rxData,
  output logic              rxDone,
  output logic              wakeReq
);
  logic [2:0] pinsS;
  logic selActive;
  logic [CHAR_W-1:0] charWord;
  dpStrobe_t strb;

  spi_addr_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN), .d({ssNIn, mosiIn, sckIn}), .q(pinsS)
  );

  spi_addr_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(pinsS[0]), .ssNS(pinsS[2]),
    .nineBit(nineBit), .addrEn(addrEn), .addrReg(addrReg),
    .addrWord(charWord[ADDR_W-1:0]), .strb(strb), .rxDone(rxDone),
    .wakeReq(wakeReq), .misoOe(misoOe), .selActive(selActive)
  );

  spi_addr_dp #(.CHAR_W(CHAR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(pinsS[1]),
    .nineBit(nineBit), .preloadEn(preloadEn), .txWrEn(txWrEn),
    .txWrData(txWrData), .misoOut(misoOut), .rxData(rxData),
    .charWord(charWord)
  );
endmodule

// File: rtl/spi_addr_chk.sv
module spi_addr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxDone,
  input logic       wakeReq,
  input logic       misoOe,
  input logic       addrEn,
  input logic       selActive,
  input logic [8:0] rxData
);
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> selActive); // R9
  AST_WAKE_WITH_RXC: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> rxDone); // R7
  AST_WAKE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(addrEn)); // R10
  AST_RXDATA_ONLY_ON_RXC: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> rxDone); // R8
  AST_RXC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone); // R2
endmodule

bind spi_addr_slave spi_addr_chk u_chk (
  .clk(clk), .rstN(rstN), .rxDone(rxDone), .wakeReq(wakeReq),
  .misoOe(misoOe), .addrEn(addrEn), .selActive(selActive), .rxData(rxData)
);

// File: tb/spi_addr_slave_tb.sv
module spi_addr_slave_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic sckIn = 1'b0, mosiIn = 1'b0, ssNIn = 1'b1;
  logic nineBit = 1'b0, addrEn = 1'b0, preloadEn = 1'b0, txWrEn = 1'b0;
  logic [7:0] addrReg = 8'h3C;
  logic [8:0] txWrData = '0;
  logic misoOut, misoOe, rxDone, wakeReq;
  logic [8:0] rxData;
  int nChecks = 0, nFails = 0, rxCnt = 0, wakeCnt = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_addr_slave u_dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .mosiIn(mosiIn), .ssNIn(ssNIn),
    .misoOut(misoOut), .misoOe(misoOe), .nineBit(nineBit), .addrEn(addrEn),
    .preloadEn(preloadEn), .addrReg(addrReg), .txWrEn(txWrEn),
    .txWrData(txWrData), .rxData(rxData), .rxDone(rxDone), .wakeReq(wakeReq)
  );

  always @(negedge clk) begin
    if (rxDone) rxCnt++;
    if (wakeReq) wakeCnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, got %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks + 1, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] v);
    @(negedge clk); txWrData = v; txWrEn = 1'b1;
    @(negedge clk); txWrEn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic selLow();
    ssNIn = 1'b0; rxCnt = 0; wakeCnt = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic selHigh();
    ssNIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [8:0] mo, output logic [8:0] mi, output logic oeAny);
    int n;
    n = nineBit ? 9 : 8;
    mi = '0; oeAny = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      mosiIn = mo[i];
      repeat (6) @(negedge clk);
      mi[i] = misoOut;
      oeAny = oeAny | misoOe;
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [8:0] mi, cand, rxBefore;
    logic oe1, oe2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 misoOe", misoOe, 0);
    chk("R1 rxData", rxData, 0);
    chk("R1 rxDone", rxDone, 0);
    chk("R1 wakeReq", wakeReq, 0);
    chk("R1 misoOut", misoOut, 0);

    // plain 8-bit, no preload
    wr(9'h0C3);
    selLow();
    xfer(9'h05A, mi, oe1);
    chk("R1 first char zero", mi, 9'h000);
    chk("R2 rxData char1", rxData, 9'h05A);
    chk("R9 oe accepted", oe1, 1);
    xfer(9'h081, mi, oe1);
    chk("R4 data loaded at boundary", mi, 9'h0C3);
    chk("R2 rxData char2", rxData, 9'h081);
    xfer(9'h066, mi, oe1);
    chk("R6 last rx resent", mi, 9'h081);
    chk("R3 rxData bit8 zero", rxData, 9'h066);
    chk("R2 rxDone count", rxCnt, 3);
    chk("R10 no wake w/o addr", wakeCnt, 0);
    selHigh();
    chk("R9 oe idle", misoOe, 0);
    selLow();
    xfer(9'h000, mi, oe1);
    chk("R4 first char is last rx", mi, 9'h066);
    selHigh();

    // preload, 8-bit
    preloadEn = 1'b1;
    wr(9'h096);
    wr(9'h02B);
    selLow();
    xfer(9'h011, mi, oe1);
    chk("R5 preloaded first", mi, 9'h096);
    xfer(9'h0E7, mi, oe1);
    chk("R5 second write held", mi, 9'h02B);
    xfer(9'h000, mi, oe1);
    chk("R6 rx resent after preload", mi, 9'h0E7);
    selHigh();

    // preload, 9-bit
    nineBit = 1'b1;
    wr(9'h1A7);
    selLow();
    xfer(9'h15C, mi, oe1);
    chk("R3 9-bit out", mi, 9'h1A7);
    chk("R3 9-bit rx", rxData, 9'h15C);
    xfer(9'h0F0, mi, oe1);
    chk("R6 9-bit resend", mi, 9'h15C);
    selHigh();
    preloadEn = 1'b0;
    nineBit = 1'b0;

    // address sweep, 8-bit
    addrEn = 1'b1;
    for (int k = 0; k < 16; k++) begin
      cand = (k % 4 == 0) ? 9'h03C : (9'h03C ^ (9'h001 << (k % 8)));
      rxBefore = rxData;
      wr(9'(9'h040 + k));
      selLow();
      xfer(cand, mi, oe1);
      chk("R9 oe off in address char", oe1, 0);
      xfer(9'(9'h090 + k), mi, oe2);
      if (cand[7:0] == addrReg) begin
        chk("R7 rxDone count", rxCnt, 2);
        chk("R7 wake pulse", wakeCnt, 1);
        chk("R9 oe after match", oe2, 1);
        chk("R7 tx after match", mi, 9'(9'h040 + k));
        chk("R7 rxData", rxData, 9'(9'h090 + k));
      end else begin
        chk("R8 no rxDone", rxCnt, 0);
        chk("R8 no wake", wakeCnt, 0);
        chk("R8 oe off", oe2, 0);
        chk("R8 rxData kept", rxData, rxBefore);
      end
      selHigh();
    end

    // address, 9-bit: only low 8 bits compared
    nineBit = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cand = (k == 0) ? 9'h13C : (k == 1) ? 9'h13D : 9'h03C;
      rxBefore = rxData;
      wr(9'h155);
      selLow();
      xfer(cand, mi, oe1);
      xfer(9'h1E1, mi, oe2);
      if (k != 1) begin
        chk("R7 9-bit match wake", wakeCnt, 1);
        chk("R7 9-bit tx", mi, 9'h155);
        chk("R3 9-bit rx after addr", rxData, 9'h1E1);
        chk("R9 9-bit oe", {oe1, oe2}, 2'b01);
      end else begin
        chk("R8 9-bit mismatch", rxCnt, 0);
        chk("R8 9-bit rx kept", rxData, rxBefore);
        chk("R8 9-bit oe", {oe1, oe2}, 2'b00);
      end
      selHigh();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule